// File: doc/BRIEF.md
# Banked Edge-Latching Interrupt Controller

This block collects up to 64 interrupt sources into one request line for a processor. The sources are split into banks of 32. Each input passes through a two-flop synchroniser. A rising edge of the synchronised input sets a sticky event bit. The edge is recorded even when the source is disabled. Software sets a per-bank enable mask, clears events by writing ones to an acknowledge word, and can read the synchronised input state directly. The request output is high while any enabled source holds a latched event.

Enabling a source whose input is already high does not create an event. Such a source raises no request until its input falls and rises again. Software that needs the interrupt must check the level word and retrigger it on its own. The banks are placed in reverse order: the lowest-numbered sources sit at the highest page of the 64-byte window. The bus port is a plain synchronous read/write port with byte addresses.

Top module: `irq_event_ctrl`

## Requirements
- R1: After reset, every enable bit and every event bit is zero, and `irq_o` is low.
- R2: Sources 0 to 31 decode at byte page 0x20 and sources 32 to 63 at page 0x10. Within a page, the words are event at +0x0, enable at +0x4, acknowledge at +0x8 and level at +0xC. Source n uses bit n mod 32, and bit 0 is data bit 0. Offsets 0x00 to 0x0F and 0x30 to 0x3F read as zero, and writes to them change nothing.
- R3: A rising edge of the synchronised input sets that source's event bit, whether or not the source is enabled.
- R4: Writing 1 to an acknowledge bit clears the matching event bit. A 0 bit leaves the event unchanged.
- R5: When an acknowledge write and a new rising edge hit the same bit in the same cycle, the event bit ends up set.
- R6: Setting an enable bit while that input is already high sets no event and raises no request.
- R7: The level word returns the synchronised input state, regardless of enable.
- R8: The enable word reads back the last value written to it.
- R9: `irq_o` is the registered OR over all banks of (event AND enable). It changes one cycle after the state that causes it.
- R10: Writes to the event and level words are ignored. The acknowledge word reads as zero.
- R11: Read data appears on the clock edge that samples `bus_rd_i` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Raw interrupt source inputs, asynchronous |
| bus_addr_i | input | 6 | Byte address within the window; bits 1:0 ignored |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A source edge presented before clock edge S reaches the second synchroniser flop at S+1. The event bit sets at S+2 and the request at S+3.

A write sampled at edge E updates enable or event at E, and the request follows at E+1. Read data is registered at the edge that samples the strobe.

The bench drives and samples on falling edges, and counts rising edges explicitly before each sample. This pins the request to its exact cycle after an enable write. It also pins the acknowledge write onto the same edge as a new rising edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BANK_W  = 32;
  localparam int SYNC_ST = 2;

  typedef enum logic [1:0] {
    REG_EVENT  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_ACK    = 2'd2,
    REG_LEVEL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqc_sync_edge.sv
module irqc_sync_edge #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o
);
  logic [STAGES-1:0][W-1:0] chain_q, chain_n;
  logic [W-1:0]             prev_q;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q <= chain_n;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;

  // R3: an edge pulse never lasts two cycles on the same bit
  p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic         en_we_i,
  input  logic         ack_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] event_o,
  output logic [W-1:0] enable_o
);
  logic [W-1:0] ev_q, ev_n, en_q, en_n;
  logic [W-1:0] clr_mask;

  always_comb begin
    clr_mask = ack_we_i ? wdata_i : '0;
    ev_n     = (ev_q & ~clr_mask) | rise_i;
    en_n     = en_q;
    if (en_we_i) en_n = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q <= '0;
      en_q <= '0;
    end else begin
      ev_q <= ev_n;
      if (en_we_i) en_q <= en_n;
    end
  end

  assign event_o  = ev_q;
  assign enable_o = en_q;

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we_i |=> ((event_o & $past(wdata_i) & ~$past(rise_i)) == '0));

  p_edge_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((event_o & $past(rise_i)) == $past(rise_i)));

  // R3 / R6: a new event bit needs an edge
  p_event_needs_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((event_o & ~$past(event_o) & ~$past(rise_i)) == '0));

  p_enable_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_we_i |=> (enable_o == $past(wdata_i)));
endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [BANK_W-1:0]   bus_wdata_i,
  output logic [BANK_W-1:0]   bus_rdata_o,
  output logic                irq_o
);
  localparam int NUM_BANKS = NUM_SRC / BANK_W;
  localparam int PAGE_W    = ADDR_W - 4;

  logic [NUM_SRC-1:0] lvl_all, rise_all;
  logic [NUM_BANKS-1:0][BANK_W-1:0] ev_all, en_all;
  logic [NUM_BANKS-1:0] hit;
  logic [1:0]           reg_sel;
  logic [BANK_W-1:0]    rdata_n, rdata_q;
  logic                 irq_n, irq_q;

  assign reg_sel = bus_addr_i[3:2];

  irqc_sync_edge #(.W(NUM_SRC), .STAGES(SYNC_ST)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (src_i),
    .level_o (lvl_all),
    .rise_o  (rise_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    // lowest source numbers at the highest page
    localparam logic [PAGE_W-1:0] PAGE = PAGE_W'(NUM_BANKS - b);
    logic en_we, ack_we;

    assign hit[b]  = (bus_addr_i[ADDR_W-1:4] == PAGE);
    assign en_we   = bus_wr_i & hit[b] & (reg_sel == REG_ENABLE);
    assign ack_we  = bus_wr_i & hit[b] & (reg_sel == REG_ACK);

    irqc_bank #(.W(BANK_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_i   (rise_all[b*BANK_W +: BANK_W]),
      .en_we_i  (en_we),
      .ack_we_i (ack_we),
      .wdata_i  (bus_wdata_i),
      .event_o  (ev_all[b]),
      .enable_o (en_all[b])
    );
  end

  always_comb begin
    rdata_n = '0;
    irq_n   = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      irq_n = irq_n | (|(ev_all[b] & en_all[b]));
      if (hit[b]) begin
        case (reg_sel)
          REG_EVENT:  rdata_n = ev_all[b];
          REG_ENABLE: rdata_n = en_all[b];
          REG_LEVEL:  rdata_n = lvl_all[b*BANK_W +: BANK_W];
          default:    rdata_n = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_rd_i) rdata_q <= rdata_n;
      irq_q <= irq_n;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> $stable(bus_rdata_o));

  // R9: with every enable bit clear, no request can appear next cycle
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all == '0) |=> !irq_o);
endmodule

// File: tb/irq_event_ctrl_bench.sv
`timescale 1ns/1ps
module irq_event_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src;
  logic [5:0]  addr;
  logic        wr, rd;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  irq_event_ctrl u_irq_event_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // called just after a falling edge
  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    @(posedge clk); @(negedge clk);
    d = rdata; rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'b0, irq}, 32'h0);
    bus_read(6'h24, v); check("R1 enable lo", v, 32'h0);
    bus_read(6'h14, v); check("R1 enable hi", v, 32'h0);
    bus_read(6'h20, v); check("R1 event lo", v, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    bus_write(6'h24, 32'hA5A5_0001);
    bus_write(6'h14, 32'h0000_8000);
    bus_read(6'h24, v); check("R8 enable lo", v, 32'hA5A5_0001);
    bus_read(6'h14, v); check("R8 enable hi", v, 32'h0000_8000);
    bus_write(6'h04, 32'hFFFF_FFFF);
    bus_write(6'h34, 32'hFFFF_FFFF);
    bus_read(6'h04, v); check("R2 unmapped read", v, 32'h0);
    bus_read(6'h24, v); check("R2 unmapped write lo", v, 32'hA5A5_0001);
    bus_read(6'h14, v); check("R2 unmapped write hi", v, 32'h0000_8000);
    bus_write(6'h24, 32'h0);
    bus_write(6'h14, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    src[3] = 1'b1; src[40] = 1'b1;
    idle(4);
    bus_read(6'h20, v); check("R3 event bank lo", v, 32'h0000_0008);
    bus_read(6'h10, v); check("R3 event bank hi", v, 32'h0000_0100);
    check("R9 disabled no irq", {31'b0, irq}, 32'h0);
    bus_read(6'h2C, v); check("R7 level lo", v, 32'h0000_0008);
    bus_read(6'h1C, v); check("R7 level hi", v, 32'h0000_0100);
  endtask

  task automatic t_irq_timing();
    addr = 6'h24; wdata = 32'h8; wr = 1'b1;
    @(posedge clk); @(negedge clk); wr = 1'b0;
    check("R9 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R9 irq one cycle later", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_ack();
    logic [31:0] v;
    bus_write(6'h28, 32'h0000_0008);
    idle(1);
    check("R9 irq drops", {31'b0, irq}, 32'h0);
    bus_read(6'h20, v); check("R4 ack clears", v, 32'h0);
    bus_read(6'h10, v); check("R4 zero bits keep", v, 32'h0000_0100);
    bus_write(6'h18, 32'h0000_0100);
    bus_read(6'h10, v); check("R4 ack hi bank", v, 32'h0);
  endtask

  task automatic t_enable_high();
    logic [31:0] v;
    src[5] = 1'b1;
    idle(4);
    bus_write(6'h28, 32'h0000_0020);
    bus_write(6'h24, 32'h0000_0028);
    idle(3);
    bus_read(6'h20, v); check("R6 no event on enable", v, 32'h0);
    check("R6 no irq on enable", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    src[5] = 1'b0;
    idle(4);
    src[5] = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_write(6'h28, 32'h0000_0020);
    bus_read(6'h20, v); check("R5 edge beats ack", v, 32'h0000_0020);
    check("R5 irq raised", {31'b0, irq}, 32'h1);
    bus_write(6'h28, 32'h0000_0020);
    idle(1);
    check("R4 irq cleared after ack", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    bus_write(6'h20, 32'hFFFF_FFFF);
    bus_write(6'h2C, 32'h0);
    bus_read(6'h20, v); check("R10 event write ignored", v, 32'h0);
    bus_read(6'h2C, v); check("R10 level write ignored", v, 32'h0000_0028);
    bus_read(6'h28, v); check("R10 ack reads zero", v, 32'h0);
    bus_read(6'h24, v);
    bus_write(6'h24, 32'h1234_0000);
    check("R11 rdata holds", rdata, 32'h0000_0028);
    bus_read(6'h24, v); check("R11 new read", v, 32'h1234_0000);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog got=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src = '0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_map();
    t_edge();
    t_irq_timing();
    t_ack();
    t_enable_high();
    t_set_wins();
    t_readonly();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule